// File: doc/BRIEF.md
# Fixed-Priority Shared-Bus Arbiter with Split Masking and Locked Sequences

This block decides which of several bus masters may drive the next address phase of a shared pipelined system bus. Index 0 is a placeholder master that only ever issues idle cycles. It exists so that the arbiter always has a safe owner to hand the bus to. Real masters take indices 1 and up, and a lower index wins. A parameter picks the master that is parked on the bus when nobody is asking for it.

The arbiter watches the transfer type, the burst code, the ready line and the response code of the shared bus. From these it tracks three things: who owns the current address phase, who owns the data phase, and whether the address-phase owner is inside a locked sequence.

A master that receives a split response is taken out of arbitration. It returns when the slave pulses that master's bit on the split-done vector. A split given to a locked transfer hands the bus to the placeholder master until the locked master can resume. A locked sequence keeps its grant and then gets one trailing unlocked transfer. Defined-length bursts keep their grant until their last beat, while open-ended bursts are arbitrated every cycle.

Top module: `mm_bus_arbiter`

## Requirements
- R1: While reset is high, the grant vector selects only master DEF_MASTER (default 1), the owner output equals DEF_MASTER, and the locked indication is low.
- R2: Exactly one grant bit is high in every cycle. The grant vector changes only at clock edges where ready is high.
- R3: At a ready edge with no lock, burst or park rule active, the grant goes to the lowest-numbered real master (index 1 and up) that is requesting and not masked. The request bit of index 0 has no effect. With no eligible request, DEF_MASTER is granted.
- R4: After every ready edge, the owner output equals the index that was granted just before that edge.
- R5: At each ready edge, the locked indication takes the lock input of the master that becomes owner. It is always low when index 0 becomes owner.
- R6: Response codes are OKAY=00, ERROR=01, RETRY=10, SPLIT=11. A SPLIT seen while ready is low masks the data-phase owner. A masked master is never granted. A one-cycle pulse on its split-done bit unmasks it, and it can be granted at the second ready edge after the pulse.
- R7: When every real master is masked, or no eligible master requests and DEF_MASTER is masked, index 0 is granted.
- R8: A SPLIT on a locked data phase parks the grant on index 0, even when other unmasked masters request. Once the split master is unmasked, it is granted at the next ready edge ahead of all others.
- R9: A RETRY masks no master and leaves priority unchanged. A master that holds its lock input high keeps the grant through a RETRY.
- R10: While the granted real master holds its lock input high and is unmasked, it keeps the grant, whatever higher-priority requests arrive.
- R11: When a locked sequence ends, the locking master keeps the grant for one more ready edge. During that transfer the locked indication is low.
- R12: Transfer codes are IDLE=00, BUSY=01, NONSEQ=10, SEQ=11. Burst codes are SINGLE=000, INCR=001, 4-beat=010/011, 8-beat=100/101, 16-beat=110/111. A NONSEQ of a defined-length burst by the address owner holds the grant with that owner until the edge that samples its final beat. BUSY beats consume no count. SINGLE and INCR are not held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_MASTERS | Bus request per master |
| lock_i | input | NUM_MASTERS | Locked-sequence request per master |
| trans_i | input | 2 | Transfer type on the bus |
| burst_i | input | 3 | Burst code on the bus |
| ready_i | input | 1 | Global ready |
| resp_i | input | 2 | Slave response code |
| split_done_i | input | NUM_MASTERS | Split completion pulses, one bit per master |
| grant_o | output | NUM_MASTERS | One-hot grant |
| owner_o | output | 4 | Index of the address-phase owner |
| owner_locked_o | output | 1 | Current address phase is locked |

## Verification
Every request pattern over the four indices is applied, including ones with the placeholder bit set. This separates the lowest-index rule from any fixed or reversed order, and the owner output confirms that the pipeline lags by one edge. Split, retry and locked-split sequences are each followed by enough idle cycles to show the difference between masking, no masking and parking on the placeholder. Each one ends with a single-cycle completion pulse, which shows the two-edge path back to the grant. Every burst code is swept with a competing higher-priority request, so the cycle of release marks out the beat count. One extra pattern with a BUSY beat shows that waiting beats are not counted.

// File: rtl/mmarb_pkg.sv
package mmarb_pkg;

    localparam int MAX_MASTERS = 16;

    typedef logic [3:0] midx_t;
    typedef logic [4:0] beats_t;

    typedef enum logic [1:0] {
        TR_IDLE = 2'b00,
        TR_BUSY = 2'b01,
        TR_NSEQ = 2'b10,
        TR_SEQ  = 2'b11
    } trans_e;

    typedef enum logic [1:0] {
        RS_OKAY  = 2'b00,
        RS_ERROR = 2'b01,
        RS_RETRY = 2'b10,
        RS_SPLIT = 2'b11
    } resp_e;

    // One pipeline stage of bus ownership
    typedef struct packed {
        midx_t owner;
        logic  locked;
    } phase_t;

    // Beats implied by a burst code; open-ended and single count as one
    function automatic beats_t burst_len(logic [2:0] code);
        beats_t n;
        case (code)
            3'b000, 3'b001: n = 5'd1;
            3'b010, 3'b011: n = 5'd4;
            3'b100, 3'b101: n = 5'd8;
            default:        n = 5'd16;
        endcase
        return n;
    endfunction

    function automatic midx_t oh_to_idx(logic [MAX_MASTERS-1:0] v);
        midx_t r = '0;
        for (int i = 0; i < MAX_MASTERS; i++)
            if (v[i]) r = midx_t'(i);
        return r;
    endfunction

endpackage

// File: rtl/arb_split_mask.sv
module arb_split_mask
    import mmarb_pkg::*;
#(
    parameter int NUM_MASTERS = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ready_i,
    input  logic [1:0]             resp_i,
    input  phase_t                 dphase_i,
    input  logic [NUM_MASTERS-1:0] split_done_i,
    output logic [MAX_MASTERS-1:0] mask_o,
    output logic                   park_o,
    output midx_t                  park_idx_o
);

    logic [NUM_MASTERS-1:0] mask_q, mask_n;
    logic                   park_q;
    midx_t                  park_idx_q;
    logic                   split_hit;
    logic [MAX_MASTERS-1:0] mask_w;

    // First cycle of a two-cycle split response names the data-phase owner
    assign split_hit = !ready_i && (resp_e'(resp_i) == RS_SPLIT) && (dphase_i.owner != '0);
    assign mask_w    = MAX_MASTERS'(mask_q);

    always_comb begin
        mask_n = mask_q & ~split_done_i;
        mask_n[0] = 1'b0;
        for (int i = 1; i < NUM_MASTERS; i++)
            if (split_hit && dphase_i.owner == midx_t'(i))
                mask_n[i] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q     <= '0;
            park_q     <= 1'b0;
            park_idx_q <= '0;
        end else begin
            mask_q <= mask_n;
            if (split_hit && dphase_i.locked) begin
                park_q     <= 1'b1;
                park_idx_q <= dphase_i.owner;
            end else if (park_q && ready_i && !mask_w[park_idx_q]) begin
                park_q <= 1'b0;
            end
        end
    end

    assign mask_o     = mask_w;
    assign park_o     = park_q;
    assign park_idx_o = park_idx_q;

    // R8: while parked the recorded master is a real one
    a_r8_park_real: assert property (@(posedge clk) disable iff (rst)
        park_q |-> park_idx_q != '0);

    // R6: the placeholder index can never be masked
    a_r6_dummy_unmasked: assert property (@(posedge clk) disable iff (rst)
        !mask_o[0]);

endmodule

// File: rtl/arb_burst_track.sv
module arb_burst_track
    import mmarb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ready_i,
    input  logic [1:0] trans_i,
    input  logic [2:0] burst_i,
    input  logic [1:0] resp_i,
    output logic       hold_o
);

    beats_t beats_q;
    trans_e tr;
    logic   resp_ok;

    assign tr      = trans_e'(trans_i);
    assign resp_ok = (resp_e'(resp_i) == RS_OKAY);

    // Keep the owner while beats remain after the one sampled now
    always_comb begin
        hold_o = 1'b0;
        if (resp_ok) begin
            case (tr)
                TR_NSEQ: hold_o = burst_len(burst_i) > 5'd1;
                TR_SEQ:  hold_o = beats_q > 5'd1;
                TR_BUSY: hold_o = beats_q != '0;
                default: hold_o = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beats_q <= '0;
        end else if (ready_i) begin
            if (!resp_ok) begin
                beats_q <= '0;
            end else begin
                case (tr)
                    TR_NSEQ: beats_q <= burst_len(burst_i) - 5'd1;
                    TR_SEQ:  beats_q <= (beats_q != '0) ? beats_q - 5'd1 : '0;
                    TR_BUSY: beats_q <= beats_q;
                    default: beats_q <= '0;
                endcase
            end
        end
    end

    // R12: count never exceeds the longest burst
    a_r12_count_range: assert property (@(posedge clk) disable iff (rst)
        beats_q <= 5'd15);

endmodule

// File: rtl/arb_grant_sel.sv
module arb_grant_sel
    import mmarb_pkg::*;
#(
    parameter int NUM_MASTERS = 4,
    parameter int DEF_MASTER  = 1
) (
    input  logic [MAX_MASTERS-1:0] req_i,
    input  logic [MAX_MASTERS-1:0] lock_i,
    input  logic [MAX_MASTERS-1:0] mask_i,
    input  midx_t                  cur_i,
    input  phase_t                 aphase_i,
    input  logic                   park_i,
    input  midx_t                  park_idx_i,
    input  logic                   burst_hold_i,
    output midx_t                  next_o,
    output logic                   all_split_o
);

    logic  found;
    midx_t top;

    always_comb begin
        found = 1'b0;
        top   = '0;
        for (int i = NUM_MASTERS - 1; i >= 1; i--) begin
            if (req_i[i] && !mask_i[i]) begin
                found = 1'b1;
                top   = midx_t'(i);
            end
        end
        all_split_o = 1'b1;
        for (int i = 1; i < NUM_MASTERS; i++)
            if (!mask_i[i]) all_split_o = 1'b0;
    end

    always_comb begin
        if (park_i)
            next_o = mask_i[park_idx_i] ? '0 : park_idx_i;
        else if (cur_i != '0 && lock_i[cur_i] && !mask_i[cur_i])
            next_o = cur_i;
        else if (aphase_i.locked && aphase_i.owner == cur_i && !mask_i[cur_i])
            next_o = cur_i;
        else if (burst_hold_i && aphase_i.owner != '0 && !mask_i[aphase_i.owner])
            next_o = aphase_i.owner;
        else if (found)
            next_o = top;
        else if (all_split_o || mask_i[DEF_MASTER])
            next_o = '0;
        else
            next_o = midx_t'(DEF_MASTER);
    end

endmodule

// File: rtl/mm_bus_arbiter.sv
module mm_bus_arbiter
    import mmarb_pkg::*;
#(
    parameter int NUM_MASTERS = 4,
    parameter int DEF_MASTER  = 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_MASTERS-1:0] req_i,
    input  logic [NUM_MASTERS-1:0] lock_i,
    input  logic [1:0]             trans_i,
    input  logic [2:0]             burst_i,
    input  logic                   ready_i,
    input  logic [1:0]             resp_i,
    input  logic [NUM_MASTERS-1:0] split_done_i,
    output logic [NUM_MASTERS-1:0] grant_o,
    output logic [3:0]             owner_o,
    output logic                   owner_locked_o
);

    localparam midx_t DEF_IDX = midx_t'(DEF_MASTER);

    logic [MAX_MASTERS-1:0] req16, lock16, mask16;
    midx_t  grant_idx_q, next_idx, park_idx;
    phase_t aphase_q, dphase_q;
    logic   park, burst_hold, all_split;

    assign req16  = MAX_MASTERS'(req_i);
    assign lock16 = MAX_MASTERS'(lock_i);

    arb_split_mask #(.NUM_MASTERS(NUM_MASTERS)) mask_i (
        .clk          (clk),
        .rst          (rst),
        .ready_i      (ready_i),
        .resp_i       (resp_i),
        .dphase_i     (dphase_q),
        .split_done_i (split_done_i),
        .mask_o       (mask16),
        .park_o       (park),
        .park_idx_o   (park_idx)
    );

    arb_burst_track burst_i0 (
        .clk     (clk),
        .rst     (rst),
        .ready_i (ready_i),
        .trans_i (trans_i),
        .burst_i (burst_i),
        .resp_i  (resp_i),
        .hold_o  (burst_hold)
    );

    arb_grant_sel #(.NUM_MASTERS(NUM_MASTERS), .DEF_MASTER(DEF_MASTER)) sel_i (
        .req_i        (req16),
        .lock_i       (lock16),
        .mask_i       (mask16),
        .cur_i        (grant_idx_q),
        .aphase_i     (aphase_q),
        .park_i       (park),
        .park_idx_i   (park_idx),
        .burst_hold_i (burst_hold),
        .next_o       (next_idx),
        .all_split_o  (all_split)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_idx_q <= DEF_IDX;
            aphase_q    <= '{owner: DEF_IDX, locked: 1'b0};
            dphase_q    <= '{owner: '0, locked: 1'b0};
        end else if (ready_i) begin
            aphase_q.owner  <= grant_idx_q;
            aphase_q.locked <= lock16[grant_idx_q] && (grant_idx_q != '0);
            dphase_q        <= aphase_q;
            grant_idx_q     <= next_idx;
        end
    end

    generate
        for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_grant
            assign grant_o[g] = (grant_idx_q == midx_t'(g));
        end
    endgenerate

    assign owner_o        = aphase_q.owner;
    assign owner_locked_o = aphase_q.locked;

    // R2: exactly one master holds the grant
    a_r2_one_hot: assert property (@(posedge clk) disable iff (rst)
        $countones(grant_o) == 1);

    // R2: grant frozen while the bus waits
    a_r2_wait_stable: assert property (@(posedge clk) disable iff (rst)
        !ready_i |=> $stable(grant_o));

    // R4: owner follows the grant seen at the previous ready edge
    a_r4_owner_tracks: assert property (@(posedge clk) disable iff (rst)
        ready_i |=> owner_o == $past(oh_to_idx(MAX_MASTERS'(grant_o))));

    // R5: placeholder master never owns a locked phase
    a_r5_dummy_unlocked: assert property (@(posedge clk) disable iff (rst)
        owner_o == '0 |-> !owner_locked_o);

    // R7: every real master split forces the placeholder
    a_r7_all_split_dummy: assert property (@(posedge clk) disable iff (rst)
        ready_i && all_split |=> grant_o[0]);

    // R8: parked on a still-masked locked master gives the placeholder
    a_r8_park_dummy: assert property (@(posedge clk) disable iff (rst)
        ready_i && park && mask16[park_idx] |=> grant_o[0]);

    // R6: a masked master is skipped at the next ready edge
    generate
        for (genvar k = 1; k < NUM_MASTERS; k++) begin : g_mask_chk
            a_r6_masked_skip: assert property (@(posedge clk) disable iff (rst)
                ready_i && mask16[k] |=> !grant_o[k]);
        end
    endgenerate

endmodule

// File: tb/mm_bus_arbiter_tb_top.sv
`timescale 1ns/1ps
module mm_bus_arbiter_tb_top;

    localparam int N   = 4;
    localparam int DEF = 1;

    localparam logic [1:0] T_IDLE = 2'b00, T_BUSY = 2'b01, T_NSEQ = 2'b10, T_SEQ = 2'b11;
    localparam logic [1:0] P_OKAY = 2'b00, P_RETRY = 2'b10, P_SPLIT = 2'b11;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req = '0, lock = '0, sdone = '0;
    logic [1:0]   trans = T_IDLE, resp = P_OKAY;
    logic [2:0]   burst = 3'b000;
    logic         ready = 1'b1;
    logic [N-1:0] grant;
    logic [3:0]   owner;
    logic         olock;

    int checks = 0;
    int errors = 0;

    mm_bus_arbiter #(.NUM_MASTERS(N), .DEF_MASTER(DEF)) dut_i (
        .clk (clk), .rst (rst), .req_i (req), .lock_i (lock),
        .trans_i (trans), .burst_i (burst), .ready_i (ready), .resp_i (resp),
        .split_done_i (sdone), .grant_o (grant), .owner_o (owner),
        .owner_locked_o (olock)
    );

    always #4 clk = ~clk;

    task automatic step();
        @(negedge clk);
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        req = '0; lock = '0; sdone = '0; trans = T_IDLE; resp = P_OKAY;
        burst = 3'b000; ready = 1'b1; rst = 1'b1;
        steps(2);
        rst = 1'b0;
    endtask

    task automatic split_resp();
        ready = 1'b0; resp = P_SPLIT; step();
        ready = 1'b1; resp = P_SPLIT; step();
        resp = P_OKAY;
    endtask

    task automatic retry_resp();
        ready = 1'b0; resp = P_RETRY; step();
        ready = 1'b1; resp = P_RETRY; step();
        resp = P_OKAY;
    endtask

    function automatic int lowest_real(logic [N-1:0] p);
        int r = DEF;
        for (int i = N - 1; i >= 1; i--) if (p[i]) r = i;
        return r;
    endfunction

    function automatic int beats_of(logic [2:0] b);
        return (b[2:1] == 2'b00) ? 1 : (2 << b[2:1]);
    endfunction

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        steps(3);
        // R1 reset state
        chk("R1 grant", grant, 32'(1 << DEF));
        chk("R1 owner", owner, DEF);
        chk("R1 locked", olock, 0);
        rst = 1'b0;

        // R3 R4 R2: every request pattern, dummy bit included
        for (int p = 0; p < (1 << N); p++) begin
            req = N'(p);
            steps(2);
            chk("R3 priority", grant, 32'(1 << lowest_real(N'(p))));
            chk("R4 owner lag", owner, lowest_real(N'(p)));
            chk("R2 one-hot", $countones(grant), 1);
        end

        // R6 split mask and single pulse unmask
        do_reset();
        req = 4'b0110; steps(3);
        chk("R6 pre", grant, 4'b0010);
        ready = 1'b0; resp = P_SPLIT; step();
        chk("R2 wait stable", grant, 4'b0010);
        ready = 1'b1; step(); resp = P_OKAY;
        chk("R6 masked", grant, 4'b0100);
        steps(3);
        chk("R6 stays masked", grant, 4'b0100);
        req = 4'b0010; step();
        chk("R7 default masked", grant, 4'b0001);
        sdone = 4'b0010; step(); sdone = '0;
        chk("R6 pulse lag", grant, 4'b0001);
        step();
        chk("R6 unmasked", grant, 4'b0010);

        // R7 every real master split
        do_reset();
        req = 4'b1110;
        for (int k = 1; k < N; k++) begin
            steps(3);
            chk("R7 walk", grant, 32'(1 << k));
            split_resp();
        end
        chk("R7 all split", grant, 4'b0001);
        step();
        chk("R7 owner dummy", owner, 0);
        chk("R5 dummy unlocked", olock, 0);
        sdone = 4'b1110; step(); sdone = '0;
        step();
        chk("R6 release all", grant, 4'b0010);

        // R8 split on locked transfer parks on dummy
        do_reset();
        req = 4'b0110; lock = 4'b0010; steps(3);
        chk("R5 locked owner", olock, 1);
        split_resp();
        chk("R8 park", grant, 4'b0001);
        steps(2);
        chk("R8 park holds", grant, 4'b0001);
        sdone = 4'b0010; step(); sdone = '0;
        step();
        chk("R8 regrant", grant, 4'b0010);

        // R9 retry without lock: no mask
        do_reset();
        req = 4'b0110; steps(3);
        retry_resp();
        steps(2);
        chk("R9 no mask", grant, 4'b0010);

        // R10 R9 R11 lock hold, retry, trailing transfer
        do_reset();
        req = 4'b0100; lock = 4'b0100; steps(2);
        req = 4'b0110; step();
        chk("R10 hold", grant, 4'b0100);
        chk("R5 locked", olock, 1);
        retry_resp();
        chk("R9 lock keeps", grant, 4'b0100);
        lock = '0; req = 4'b0010; step();
        chk("R11 extra grant", grant, 4'b0100);
        chk("R11 owner", owner, 2);
        chk("R11 unlocked", olock, 0);
        step();
        chk("R11 release", grant, 4'b0010);
        chk("R11 owner lag", owner, 2);
        step();
        chk("R4 new owner", owner, 1);

        // R12 every burst code against a higher-priority request
        for (int b = 0; b < 8; b++) begin
            do_reset();
            req = 4'b0100; steps(2);
            req = 4'b0110; trans = T_NSEQ; burst = 3'(b); step();
            chk("R12 first beat", grant, (beats_of(3'(b)) > 1) ? 4'b0100 : 4'b0010);
            for (int s = 1; s < beats_of(3'(b)); s++) begin
                trans = T_SEQ; step();
                chk("R12 beat", grant, (s < beats_of(3'(b)) - 1) ? 4'b0100 : 4'b0010);
            end
            trans = T_IDLE;
        end

        // R12 BUSY beat does not consume the count
        do_reset();
        req = 4'b0100; steps(2);
        req = 4'b0110; burst = 3'b011;
        trans = T_NSEQ; step(); chk("R12 busy n", grant, 4'b0100);
        trans = T_SEQ;  step(); chk("R12 busy s1", grant, 4'b0100);
        trans = T_BUSY; step(); chk("R12 busy b", grant, 4'b0100);
        trans = T_SEQ;  step(); chk("R12 busy s2", grant, 4'b0100);
        trans = T_SEQ;  step(); chk("R12 busy s3", grant, 4'b0010);
        trans = T_IDLE;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule